// File: doc/BRIEF.md
# Five-Instruction RISC-V Core

This block is a 32-bit RISC-V core that executes one instruction per clock and understands only five instructions: AUIPC, ADDI, LW, SW and JALR. Its single arithmetic unit is an adder. That adder computes ADDI results, AUIPC results (the PC plus the upper immediate), load and store addresses, and jump targets. The core is meant to run a short program that builds instruction words, stores them into memory and then jumps to them. For that reason it treats instruction memory and data memory as one address space.

The core has two combinational ports into one shared word memory. The fetch port presents the PC and takes the instruction word back in the same cycle. The data port presents a word-aligned address, write data and a write strobe, and takes read data back in the same cycle. A store becomes visible to the next fetch from that address. There are no system calls and no traps, so test results are read through a combinational debug port that returns the register selected by an index input. Any encoding outside the five supported ones is executed as a no-op.

Top module: `tiny_rv_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC is loaded with the parameter `RESET_PC` (default 0x0000_1000) and every register is cleared to zero. During reset `dmem_we` stays low.
- R2: AUIPC (opcode bits [6:0] = 0010111) writes PC + {instr[31:12], 12'b0} to rd.
- R3: ADDI (opcode 0010011 with funct3 bits [14:12] = 000) writes rs1 + sign-extended instr[31:20] to rd.
- R4: LW (opcode 0000011, funct3 010) drives `dmem_addr` = (rs1 + sign-extended instr[31:20]) with bits [1:0] forced to zero, keeps `dmem_we` low, and writes `dmem_rdata` to rd.
- R5: SW (opcode 0100011, funct3 010) raises `dmem_we` for that cycle. It drives `dmem_addr` = (rs1 + sign-extended {instr[31:25], instr[11:7]}) with bits [1:0] cleared and drives `dmem_wdata` = rs2. It changes no register.
- R6: JALR (opcode 1100111, funct3 000) writes PC + 4 to rd. The next PC is (rs1 + sign-extended instr[31:20]) with bit 0 cleared.
- R7: Register x0 always reads as zero. Writes that target it are discarded.
- R8: Every other encoding, including the supported opcodes with any other funct3, is a no-op. It advances the PC by 4, writes no register and raises no store.
- R9: `imem_addr` equals the PC in every cycle, and each rising edge out of reset retires exactly one instruction. A word stored by SW is executed when later fetched, so code copied into memory runs correctly.
- R10: `dbg_data` returns the current value of the register selected by `dbg_idx` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Fetch address (current PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Word-aligned data address |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, same cycle |
| dbg_idx | input | 5 | Debug register index |
| dbg_data | output | 32 | Value of register `dbg_idx` |

## Verification
The in-RTL assertions check the following on every cycle:
- Each non-jump instruction, including unknown encodings, advances the PC by exactly 4.
- A JALR never leaves an odd PC.
- Every store address is word-aligned, and a store never writes a register.
- The debug port returns zero for x0.

The following can only be shown by the bench's scenarios, where a reference model running in lockstep predicts each register value, store and next PC:
- The arithmetic results of AUIPC, ADDI, LW and JALR.
- Loads returning stored data.
- The encode, copy and execute sequence producing the value that the copied instruction should compute.
- A reset in the middle of a run clearing state that was not zero.

// File: rtl/tiny_rv_pkg.sv
package tiny_rv_pkg;

    localparam int XLEN   = 32;
    localparam int NREG   = 32;
    localparam int RIDX_W = $clog2(NREG);

    localparam logic [6:0] OPC_AUIPC = 7'b0010111;
    localparam logic [6:0] OPC_OPIMM = 7'b0010011;
    localparam logic [6:0] OPC_LOAD  = 7'b0000011;
    localparam logic [6:0] OPC_STORE = 7'b0100011;
    localparam logic [6:0] OPC_JALR  = 7'b1100111;

    localparam logic [2:0] F3_ADD  = 3'b000;
    localparam logic [2:0] F3_WORD = 3'b010;

    typedef enum logic [2:0] {
        K_NOP, K_AUIPC, K_ADDI, K_LW, K_SW, K_JALR
    } kind_e;

    typedef struct packed {
        kind_e             kind;
        logic [RIDX_W-1:0] rd;
        logic [RIDX_W-1:0] rs1;
        logic [RIDX_W-1:0] rs2;
        logic [XLEN-1:0]   imm;
        logic              wb;
    } ctrl_t;

    function automatic logic [XLEN-1:0] imm_i(input logic [31:0] w);
        return {{(XLEN-12){w[31]}}, w[31:20]};
    endfunction

    function automatic logic [XLEN-1:0] imm_s(input logic [31:0] w);
        return {{(XLEN-12){w[31]}}, w[31:25], w[11:7]};
    endfunction

    function automatic logic [XLEN-1:0] imm_u(input logic [31:0] w);
        return {w[31:12], 12'b0};
    endfunction

endpackage

// File: rtl/trv_decode.sv
module trv_decode
    import tiny_rv_pkg::*;
(
    input  logic [31:0] instr,
    output ctrl_t       ctl
);
    logic [6:0] opc;
    logic [2:0] f3;

    assign opc = instr[6:0];
    assign f3  = instr[14:12];

    always_comb begin
        ctl      = '0;
        ctl.kind = K_NOP;
        ctl.rd   = instr[11:7];
        ctl.rs1  = instr[19:15];
        ctl.rs2  = instr[24:20];
        if (opc == OPC_AUIPC) begin
            ctl.kind = K_AUIPC;
            ctl.imm  = imm_u(instr);
        end else if (opc == OPC_OPIMM && f3 == F3_ADD) begin
            ctl.kind = K_ADDI;
            ctl.imm  = imm_i(instr);
        end else if (opc == OPC_LOAD && f3 == F3_WORD) begin
            ctl.kind = K_LW;
            ctl.imm  = imm_i(instr);
        end else if (opc == OPC_STORE && f3 == F3_WORD) begin
            ctl.kind = K_SW;
            ctl.imm  = imm_s(instr);
        end else if (opc == OPC_JALR && f3 == F3_ADD) begin
            ctl.kind = K_JALR;
            ctl.imm  = imm_i(instr);
        end
        ctl.wb = (ctl.kind == K_AUIPC) || (ctl.kind == K_ADDI) ||
                 (ctl.kind == K_LW)    || (ctl.kind == K_JALR);
    end
endmodule

// File: rtl/trv_adder.sv
module trv_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    assign sum = a + b;
endmodule

// File: rtl/trv_regfile.sv
module trv_regfile
    import tiny_rv_pkg::*;
#(
    parameter int NRP = 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         we,
    input  logic [RIDX_W-1:0]            wa,
    input  logic [XLEN-1:0]              wd,
    input  logic [NRP-1:0][RIDX_W-1:0]   ra,
    output logic [NRP-1:0][XLEN-1:0]     rdat
);
    logic [XLEN-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else begin
            for (int i = 1; i < NREG; i++) begin
                if (we && wa == RIDX_W'(i)) regs[i] <= wd;
            end
        end
    end

    for (genvar p = 0; p < NRP; p++) begin : g_rport
        assign rdat[p] = (ra[p] == '0) ? '0 : regs[ra[p]];
    end
endmodule

// File: rtl/tiny_rv_core.sv
module tiny_rv_core
    import tiny_rv_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0000_1000
) (
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_rdata,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata,
    output logic        dmem_we,
    input  logic [31:0] dmem_rdata,
    input  logic [4:0]  dbg_idx,
    output logic [31:0] dbg_data
);
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    logic [XLEN-1:0] pc_q, pc_d;
    ctrl_t           ctl;
    logic [XLEN-1:0] op_a, sum, link, wb_data;
    logic [2:0][RIDX_W-1:0] rd_idx;
    logic [2:0][XLEN-1:0]   rd_val;

    trv_decode u_dec (.instr(imem_rdata), .ctl(ctl));

    assign rd_idx = {dbg_idx, ctl.rs2, ctl.rs1};

    trv_regfile #(.NRP(3)) u_rf (
        .clk  (clk),
        .rst  (rst),
        .we   (ctl.wb && !rst),
        .wa   (ctl.rd),
        .wd   (wb_data),
        .ra   (rd_idx),
        .rdat (rd_val)
    );

    assign op_a = (ctl.kind == K_AUIPC) ? pc_q : rd_val[0];

    trv_adder #(.W(XLEN)) u_alu (.a(op_a), .b(ctl.imm), .sum(sum));
    trv_adder #(.W(XLEN)) u_inc (.a(pc_q), .b(STEP),    .sum(link));

    always_comb begin
        case (ctl.kind)
            K_AUIPC, K_ADDI: wb_data = sum;
            K_LW:            wb_data = dmem_rdata;
            K_JALR:          wb_data = link;
            default:         wb_data = '0;
        endcase
    end

    assign pc_d = (ctl.kind == K_JALR) ? (sum & ~XLEN'(1)) : link;

    always_ff @(posedge clk) begin
        if (rst) pc_q <= RESET_PC;
        else     pc_q <= pc_d;
    end

    assign imem_addr  = pc_q;
    assign dmem_addr  = sum & ~XLEN'(3);
    assign dmem_wdata = rd_val[1];
    assign dmem_we    = (ctl.kind == K_SW) && !rst;
    assign dbg_data   = rd_val[2];

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (ctl.kind != K_JALR) |=> (pc_q == $past(pc_q) + STEP))
        else $error("non-jump did not advance pc by 4"); // R8
    AST_JALR_EVEN: assert property (@(posedge clk) disable iff (rst)
        (ctl.kind == K_JALR) |=> (pc_q[0] == 1'b0))
        else $error("jalr left odd pc"); // R6
    AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> (dmem_addr[1:0] == 2'b00))
        else $error("unaligned store"); // R5
    AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> !ctl.wb)
        else $error("store wrote a register"); // R5
    AST_X0_ZERO: assert property (@(posedge clk) disable iff (rst)
        (dbg_idx == 5'd0) |-> (dbg_data == '0))
        else $error("x0 not zero"); // R7
endmodule

// File: tb/sim_tiny_rv_core.sv
module sim_tiny_rv_core;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] RST_PC = 32'h0000_1000;
    localparam int MEM_WORDS = 4096;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata, dbg_data;
    logic        dmem_we;
    logic [4:0]  dbg_idx = 5'd0;

    logic [31:0] mem     [MEM_WORDS];
    logic [31:0] ref_mem [MEM_WORDS];
    logic [31:0] ref_x   [32];
    logic [31:0] ref_pc;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    string pc_tag = "R1";
    string pr_tag = "R10";
    int    probe  = 0;

    tiny_rv_core #(.RESET_PC(RST_PC)) u0 (
        .clk(clk), .rst(rst),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
        .dmem_we(dmem_we), .dmem_rdata(dmem_rdata),
        .dbg_idx(dbg_idx), .dbg_data(dbg_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int ix(input logic [31:0] a);
        return int'(a[13:2]);
    endfunction

    assign imem_rdata = mem[ix(imem_addr)];
    assign dmem_rdata = mem[ix(dmem_addr)];

    always @(posedge clk) if (dmem_we) mem[ix(dmem_addr)] <= dmem_wdata;

    function automatic logic [31:0] enc_i(input logic [6:0] op, input logic [4:0] rd,
                                          input logic [2:0] f3, input logic [4:0] rs1,
                                          input logic [11:0] imm);
        return {imm, rs1, f3, rd, op};
    endfunction
    function automatic logic [31:0] enc_s(input logic [4:0] rs2, input logic [4:0] rs1,
                                          input logic [11:0] imm);
        return {imm[11:5], rs2, rs1, 3'b010, imm[4:0], 7'b0100011};
    endfunction
    function automatic logic [31:0] enc_u(input logic [4:0] rd, input logic [19:0] imm);
        return {imm, rd, 7'b0010111};
    endfunction

    function automatic logic [31:0] rand_instr();
        logic [4:0] a, b;
        logic [11:0] im;
        a  = 5'($urandom);
        b  = 5'($urandom);
        im = 12'($urandom);
        case ($urandom % 8)
            0: return enc_u(a, 20'($urandom));
            1, 2: return enc_i(7'b0010011, a, 3'b000, b, im);
            3: return enc_i(7'b0000011, a, 3'b010, b, im);
            4: return enc_s(a, b, im);
            5: return enc_i(7'b1100111, a, 3'b000, b, im);
            6: return $urandom;
            default: return enc_i(7'b0010011, a, 3'b010, b, im);
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Reset: checks PC and all registers while rst is held (R1)
    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 pc", imem_addr, RST_PC);
        chk("R1 we", {31'b0, dmem_we}, 32'd0);
        for (int r = 0; r < 32; r++) begin
            dbg_idx = 5'(r);
            #1;
            chk("R1 reg", dbg_data, 32'd0);
        end
        ref_pc = RST_PC;
        for (int r = 0; r < 32; r++) ref_x[r] = 32'd0;
        pc_tag = "R1";
        pr_tag = "R10";
        probe  = 0;
        rst = 1'b0;
    endtask

    // One lockstep cycle, called at a negative edge
    task automatic step();
        logic [31:0] w, a1, a2, ea, nx_pc;
        logic [6:0] op;
        logic [2:0] f3;
        logic [4:0] rd, rs1, rs2;
        logic wb;
        logic [31:0] wv;
        string kt;
        chk({pc_tag, " pc"}, imem_addr, ref_pc);
        dbg_idx = 5'(probe);
        #1;
        chk({pr_tag, " dbg"}, dbg_data, ref_x[probe]);

        w   = ref_mem[ix(ref_pc)];
        op  = w[6:0]; f3 = w[14:12];
        rd  = w[11:7]; rs1 = w[19:15]; rs2 = w[24:20];
        a1  = ref_x[rs1]; a2 = ref_x[rs2];
        nx_pc = ref_pc + 32'd4;
        wb = 1'b0; wv = 32'd0; kt = "R8";
        if (op == 7'b0010111) begin
            wb = 1'b1; wv = ref_pc + {w[31:12], 12'b0}; kt = "R2";
        end else if (op == 7'b0010011 && f3 == 3'b000) begin
            wb = 1'b1; wv = a1 + {{20{w[31]}}, w[31:20]}; kt = "R3";
        end else if (op == 7'b0000011 && f3 == 3'b010) begin
            ea = (a1 + {{20{w[31]}}, w[31:20]}) & ~32'd3;
            chk("R4 addr", dmem_addr, ea);
            wb = 1'b1; wv = ref_mem[ix(ea)]; kt = "R4";
        end else if (op == 7'b0100011 && f3 == 3'b010) begin
            kt = "R5";
        end else if (op == 7'b1100111 && f3 == 3'b000) begin
            wb = 1'b1; wv = ref_pc + 32'd4; kt = "R6";
            nx_pc = (a1 + {{20{w[31]}}, w[31:20]}) & ~32'd1;
        end

        if (kt == "R5") begin
            ea = (a1 + {{20{w[31]}}, w[31:25], w[11:7]}) & ~32'd3;
            chk("R5 we", {31'b0, dmem_we}, 32'd1);
            chk("R5 addr", dmem_addr, ea);
            chk("R5 wdata", dmem_wdata, a2);
            ref_mem[ix(ea)] = a2;
        end else begin
            chk({kt, " no store"}, {31'b0, dmem_we}, 32'd0);
        end

        if (wb && rd != 5'd0) begin
            ref_x[rd] = wv;
            probe = int'(rd);
            pr_tag = kt;
        end else if (wb) begin
            probe = 0;
            pr_tag = "R7";
        end else begin
            probe = int'($urandom % 32);
            pr_tag = "R10";
        end
        ref_pc = nx_pc;
        pc_tag = (kt == "R6") ? "R6" : ((kt == "R8") ? "R8" : "R9");
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd_dbg(input int r, output logic [31:0] v);
        dbg_idx = 5'(r);
        #1;
        v = dbg_data;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v, add_w, spin_w;
        void'($urandom(32'd20240611));

        // Directed self-modifying program (R9, R6, R7, R8)
        add_w  = enc_i(7'b0010011, 5'd5, 3'b000, 5'd0, 12'd42);
        spin_w = enc_i(7'b1100111, 5'd0, 3'b000, 5'd10, 12'h204);
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = 32'd0;
        mem[ix(32'h1000)] = enc_u(5'd10, 20'd0);
        mem[ix(32'h1004)] = enc_i(7'b0010011, 5'd0, 3'b000, 5'd0, 12'd5);
        mem[ix(32'h1008)] = 32'h0000_0033;
        mem[ix(32'h100c)] = enc_i(7'b0000011, 5'd11, 3'b010, 5'd10, 12'h100);
        mem[ix(32'h1010)] = enc_s(5'd11, 5'd10, 12'h200);
        mem[ix(32'h1014)] = enc_i(7'b0000011, 5'd12, 3'b010, 5'd10, 12'h104);
        mem[ix(32'h1018)] = enc_s(5'd12, 5'd10, 12'h204);
        mem[ix(32'h101c)] = enc_i(7'b1100111, 5'd1, 3'b000, 5'd10, 12'h201);
        mem[ix(32'h1100)] = add_w;
        mem[ix(32'h1104)] = spin_w;
        for (int i = 0; i < MEM_WORDS; i++) ref_mem[i] = mem[i];

        do_reset();
        for (int c = 0; c < 40; c++) step();

        rd_dbg(5, v);  chk("R9 copied code result x5", v, 32'd42);
        rd_dbg(1, v);  chk("R6 link x1", v, 32'h0000_1020);
        rd_dbg(10, v); chk("R2 auipc x10", v, 32'h0000_1000);
        rd_dbg(11, v); chk("R4 loaded word x11", v, add_w);
        rd_dbg(0, v);  chk("R7 x0 after addi x0", v, 32'd0);
        chk("R6 spin pc", imem_addr, 32'h0000_1204);
        chk("R5 stored word", mem[ix(32'h1200)], add_w);

        // Constrained random programs in lockstep with the reference model
        for (int i = 0; i < MEM_WORDS; i++) begin
            mem[i] = rand_instr();
            ref_mem[i] = mem[i];
        end
        do_reset();
        for (int c = 0; c < 1500; c++) step();
        do_reset();
        for (int c = 0; c < 1500; c++) step();

        done = 1;
        finish_run();
    end
endmodule